// File: doc/BRIEF.md
# Register-15 Commit and Status Update Unit

This block is the last stage of a data-processing instruction in a core whose register 15 holds both the program counter and the processor status. It gets the finished ALU result together with the ALU and shifter flag outputs, the destination register index, the set-flags bit, a marker for comparison-type operations and a commit strobe. From these it decides what gets written: the general register file, the program-counter field, the condition flags, and the privileged status bits (interrupt masks and mode).

The unit owns the status state and the 24-bit word-address program counter. It always presents the combined 32-bit register-15 view. A write to any register other than 15 goes out through a combinational write port, which the register file captures on the same clock edge that updates the status. A destination of 15 follows its own rules. These depend on the set-flags bit, on whether the operation is a comparison, and on the current mode. In user mode the interrupt masks and mode bits are protected from change.

Top module: `r15_writeback`

## Requirements
- R1: After a synchronous active-low reset the PC field is 0, N, Z, C and V are 0, both interrupt masks are 1, and the mode is 2'b11, so `r15_q` reads 32'h0C00_0003.
- R2: While `commit_valid` is low, `rf_we` is 0 and no state changes, whatever the other inputs hold.
- R3: A committed non-comparison operation whose destination is not 15 asserts `rf_we` with `rf_waddr` equal to the destination and `rf_wdata` equal to the result. With the set-flags bit clear, all flags keep their values.
- R4: When the destination is not 15 and set-flags is 1, N and Z are loaded from `alu_n` and `alu_z`. For a logical operation (`arith_op`=0), C is loaded from `shift_c` and V is left unchanged.
- R5: When the destination is not 15, set-flags is 1 and `arith_op`=1, C is loaded from `alu_c` and V from `alu_v`.
- R6: A comparison operation never asserts `rf_we`. With set-flags clear it changes no flag.
- R7: When the destination is 15 and set-flags is clear, a non-comparison loads the PC field from result bits 25:2, and every status bit keeps its value.
- R8: When the destination is 15 and set-flags is 1 in a privileged mode (mode not 2'b00), N, Z, C, V come from result bits 31..28. The IRQ mask comes from bit 27, the FIQ mask from bit 26, and the mode from bits 1:0. A non-comparison also loads the PC from bits 25:2.
- R9: In user mode (mode 2'b00), a destination-15 write with set-flags 1 changes only N, Z, C, V. The interrupt masks and mode keep their values.
- R10: A comparison with destination 15 never changes the PC field. With set-flags 1 it updates the status as in R8/R9. With set-flags clear it changes nothing.
- R11: A destination of 15 never asserts `rf_we`.
- R12: `r15_q` is packed as {N, Z, C, V, IRQ mask, FIQ mask, PC[23:0], mode[1:0]}. The separate flag, mask, mode and PC outputs equal the matching fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| commit_valid | input | 1 | Commit the presented instruction on this edge |
| result | input | 32 | ALU result |
| alu_n | input | 1 | ALU negative flag |
| alu_z | input | 1 | ALU zero flag |
| alu_c | input | 1 | Adder carry out |
| alu_v | input | 1 | Adder overflow |
| shift_c | input | 1 | Barrel-shifter carry out |
| arith_op | input | 1 | 1 for arithmetic, 0 for logical operations |
| dest | input | 4 | Destination register index |
| set_flags | input | 1 | Set-flags bit of the instruction |
| is_compare | input | 1 | Operation produces no register result |
| rf_we | output | 1 | Register-file write enable |
| rf_waddr | output | 4 | Register-file write index |
| rf_wdata | output | 32 | Register-file write data |
| pc_q | output | 24 | Word-address program counter |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| irq_mask | output | 1 | IRQ disable bit |
| fiq_mask | output | 1 | FIQ disable bit |
| mode | output | 2 | Processor mode, 2'b00 is user |
| r15_q | output | 32 | Combined PC and status word |

## Verification
The assertions check on every cycle the properties that hold for any instruction: the write port stays silent for comparisons and for register 15, an idle cycle freezes the whole register-15 word, user mode can never release the masks or leave the mode, and a PC-only write leaves the status untouched. They also check that comparisons never move the PC. The bench scenarios are needed for the exact values. This covers the bit-to-field mapping from the result, the choice between adder and shifter carry, V being held on logical operations, and the sequence that enters user mode through a privileged register-15 write and then meets the protection.

// File: rtl/r15_commit_pkg.sv
// Shared constants and the status type for the register-15 commit unit.
// Assumes the 32-bit combined word layout {N,Z,C,V,I,F,PC[23:0],M1,M0}.
package r15_commit_pkg;

    localparam int WORD_W = 32;
    localparam int IDX_W  = 4;
    localparam int PC_W   = 24;
    localparam int PC_LSB = 2;
    localparam int MODE_W = 2;

    localparam logic [IDX_W-1:0] PC_IDX = IDX_W'((1 << IDX_W) - 1);

    // Bit positions of the status fields within the combined word.
    localparam int N_BIT   = WORD_W - 1;
    localparam int Z_BIT   = WORD_W - 2;
    localparam int C_BIT   = WORD_W - 3;
    localparam int V_BIT   = WORD_W - 4;
    localparam int IRQ_BIT = WORD_W - 5;
    localparam int FIQ_BIT = WORD_W - 6;

    localparam logic [MODE_W-1:0] MODE_USER  = '0;
    localparam logic [MODE_W-1:0] MODE_RESET = '1;

    typedef struct packed {
        logic              n;
        logic              z;
        logic              c;
        logic              v;
        logic              irq_off;
        logic              fiq_off;
        logic [MODE_W-1:0] mode;
    } psr_t;

    typedef enum logic [1:0] {
        PSR_KEEP = 2'd0,
        PSR_CC   = 2'd1,
        PSR_LOAD = 2'd2
    } psr_sel_e;

    localparam psr_t PSR_RESET = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0,
                                   irq_off: 1'b1, fiq_off: 1'b1,
                                   mode: MODE_RESET};

    // Build the combined register-15 word from status and PC.
    function automatic logic [WORD_W-1:0] pack_r15(input psr_t p,
                                                   input logic [PC_W-1:0] pc);
        return {p.n, p.z, p.c, p.v, p.irq_off, p.fiq_off, pc, p.mode};
    endfunction

endpackage

// File: rtl/r15_commit_ctrl.sv
// Decodes a commit into write strobes and a status-source select.
// Assumes the register file captures rf_we on the same edge as the status.
module r15_commit_ctrl
    import r15_commit_pkg::*;
(
    input  logic             commit_valid,
    input  logic [IDX_W-1:0] dest,
    input  logic             set_flags,
    input  logic             is_compare,
    output logic             rf_we,
    output logic             pc_we,
    output psr_sel_e         psr_sel
);

    logic dest_is_pc;

    // Identify the combined PC/status register as destination.
    always_comb dest_is_pc = (dest == PC_IDX);

    // Register-file and PC strobes; comparisons produce no register result.
    always_comb begin
        rf_we = commit_valid && !is_compare && !dest_is_pc;
        pc_we = commit_valid && !is_compare &&  dest_is_pc;
    end

    // Pick where the next status comes from.
    always_comb begin
        if (!commit_valid || !set_flags) psr_sel = PSR_KEEP;
        else if (dest_is_pc)             psr_sel = PSR_LOAD;
        else                             psr_sel = PSR_CC;
    end

endmodule

// File: rtl/r15_cc_update.sv
// Condition-flag update for a destination other than register 15.
// Logical operations take C from the shifter and keep V; arithmetic ones
// take C and V from the adder. Masks and mode pass through untouched.
module r15_cc_update
    import r15_commit_pkg::*;
(
    input  psr_t cur,
    input  logic alu_n,
    input  logic alu_z,
    input  logic alu_c,
    input  logic alu_v,
    input  logic shift_c,
    input  logic arith_op,
    output psr_t nxt
);

    // Merge the ALU flags into the current status.
    always_comb begin
        nxt   = cur;
        nxt.n = alu_n;
        nxt.z = alu_z;
        nxt.c = arith_op ? alu_c : shift_c;
        nxt.v = arith_op ? alu_v : cur.v;
    end

endmodule

// File: rtl/r15_psr_load.sv
// Status load from a result word written to register 15 with set-flags.
// Condition flags always follow the result; masks and mode only do so
// outside user mode (judged from the mode before the write).
module r15_psr_load
    import r15_commit_pkg::*;
(
    input  psr_t              cur,
    input  logic [WORD_W-1:0] result,
    output psr_t              nxt
);

    logic privileged;

    // Protection follows the mode in force before the commit.
    always_comb privileged = (cur.mode != MODE_USER);

    // Apply the result bits, masking the protected ones in user mode.
    always_comb begin
        nxt   = cur;
        nxt.n = result[N_BIT];
        nxt.z = result[Z_BIT];
        nxt.c = result[C_BIT];
        nxt.v = result[V_BIT];
        if (privileged) begin
            nxt.irq_off = result[IRQ_BIT];
            nxt.fiq_off = result[FIQ_BIT];
            nxt.mode    = result[MODE_W-1:0];
        end
    end

endmodule

// File: rtl/r15_writeback.sv
// Commit stage for data-processing results in a core whose register 15
// combines PC and status. Holds the status and PC, drives the register
// file write port, and applies the register-15 rules in one clock edge.
module r15_writeback
    import r15_commit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_valid,
    input  logic [WORD_W-1:0] result,
    input  logic              alu_n,
    input  logic              alu_z,
    input  logic              alu_c,
    input  logic              alu_v,
    input  logic              shift_c,
    input  logic              arith_op,
    input  logic [IDX_W-1:0]  dest,
    input  logic              set_flags,
    input  logic              is_compare,
    output logic              rf_we,
    output logic [IDX_W-1:0]  rf_waddr,
    output logic [WORD_W-1:0] rf_wdata,
    output logic [PC_W-1:0]   pc_q,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v,
    output logic              irq_mask,
    output logic              fiq_mask,
    output logic [MODE_W-1:0] mode,
    output logic [WORD_W-1:0] r15_q
);

    psr_t     psr_q;
    psr_t     psr_d;
    psr_t     psr_cc;
    psr_t     psr_ld;
    psr_sel_e psr_sel;
    logic     pc_we;

    r15_commit_ctrl u_ctrl (
        .commit_valid (commit_valid),
        .dest         (dest),
        .set_flags    (set_flags),
        .is_compare   (is_compare),
        .rf_we        (rf_we),
        .pc_we        (pc_we),
        .psr_sel      (psr_sel)
    );

    r15_cc_update u_cc (
        .cur      (psr_q),
        .alu_n    (alu_n),
        .alu_z    (alu_z),
        .alu_c    (alu_c),
        .alu_v    (alu_v),
        .shift_c  (shift_c),
        .arith_op (arith_op),
        .nxt      (psr_cc)
    );

    r15_psr_load u_load (
        .cur    (psr_q),
        .result (result),
        .nxt    (psr_ld)
    );

    // Register-file port carries the destination and result directly.
    always_comb begin
        rf_waddr = dest;
        rf_wdata = result;
    end

    // Next status from the selected source.
    always_comb begin
        unique case (psr_sel)
            PSR_CC:   psr_d = psr_cc;
            PSR_LOAD: psr_d = psr_ld;
            default:  psr_d = psr_q;
        endcase
    end

    // Status and PC state, updated together on the commit edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psr_q <= PSR_RESET;
            pc_q  <= '0;
        end else begin
            psr_q <= psr_d;
            if (pc_we) pc_q <= result[PC_LSB +: PC_W];
        end
    end

    // Field views of the held state.
    always_comb begin
        flag_n   = psr_q.n;
        flag_z   = psr_q.z;
        flag_c   = psr_q.c;
        flag_v   = psr_q.v;
        irq_mask = psr_q.irq_off;
        fiq_mask = psr_q.fiq_off;
        mode     = psr_q.mode;
        r15_q    = pack_r15(psr_q, pc_q);
    end

endmodule

// File: rtl/r15_writeback_chk.sv
// Cycle-by-cycle properties of the register-15 commit unit, bound to the top.
module r15_writeback_chk
    import r15_commit_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              commit_valid,
    input logic              alu_n,
    input logic              alu_z,
    input logic [IDX_W-1:0]  dest,
    input logic              set_flags,
    input logic              is_compare,
    input logic              rf_we,
    input logic              irq_mask,
    input logic              fiq_mask,
    input logic              flag_n,
    input logic              flag_z,
    input logic [MODE_W-1:0] mode,
    input logic [PC_W-1:0]   pc_q,
    input logic [WORD_W-1:0] r15_q
);

    // R6: comparisons never reach the register file
    assert_no_rf_write_compare_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !is_compare);

    // R11: register 15 is never a register-file target
    assert_no_rf_write_r15_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (dest != PC_IDX));

    // R2: idle cycles freeze the combined word
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_valid |=> $stable(r15_q));

    // R9: user mode cannot leave itself or change the masks
    assert_user_protect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_USER) |=> (mode == MODE_USER) && $stable(irq_mask) && $stable(fiq_mask));

    // R7: PC-only write keeps every status bit
    assert_pc_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && dest == PC_IDX && !set_flags)
        |=> $stable(r15_q[WORD_W-1:PC_LSB+PC_W]) && $stable(r15_q[MODE_W-1:0]));

    // R10: comparisons never move the PC
    assert_cmp_pc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && is_compare) |=> $stable(pc_q));

    // R4: N and Z follow the ALU for flag-setting non-PC destinations
    assert_nz_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && set_flags && dest != PC_IDX)
        |=> (flag_n == $past(alu_n)) && (flag_z == $past(alu_z)));

endmodule

bind r15_writeback r15_writeback_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .commit_valid (commit_valid),
    .alu_n        (alu_n),
    .alu_z        (alu_z),
    .dest         (dest),
    .set_flags    (set_flags),
    .is_compare   (is_compare),
    .rf_we        (rf_we),
    .irq_mask     (irq_mask),
    .fiq_mask     (fiq_mask),
    .flag_n       (flag_n),
    .flag_z       (flag_z),
    .mode         (mode),
    .pc_q         (pc_q),
    .r15_q        (r15_q)
);

// File: tb/tb_r15_writeback.sv
`timescale 1ns/1ps
module tb_r15_writeback;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        commit_valid = 1'b0;
    logic [31:0] result = '0;
    logic        alu_n = 1'b0, alu_z = 1'b0, alu_c = 1'b0, alu_v = 1'b0, shift_c = 1'b0;
    logic        arith_op = 1'b0, set_flags = 1'b0, is_compare = 1'b0;
    logic [3:0]  dest = '0;
    logic        rf_we;
    logic [3:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic [23:0] pc_q;
    logic        flag_n, flag_z, flag_c, flag_v, irq_mask, fiq_mask;
    logic [1:0]  mode;
    logic [31:0] r15_q;

    int n_checks = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    r15_writeback dut (
        .clk(clk), .rst_n(rst_n), .commit_valid(commit_valid), .result(result),
        .alu_n(alu_n), .alu_z(alu_z), .alu_c(alu_c), .alu_v(alu_v), .shift_c(shift_c),
        .arith_op(arith_op), .dest(dest), .set_flags(set_flags), .is_compare(is_compare),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .pc_q(pc_q),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .irq_mask(irq_mask), .fiq_mask(fiq_mask), .mode(mode), .r15_q(r15_q)
    );

    typedef struct packed {
        logic [3:0]  dest;
        logic        s;
        logic        cmp;
        logic        arith;
        logic        an;
        logic        az;
        logic        ac;
        logic        av;
        logic        sc;
        logic [31:0] res;
        logic        exp_we;
        logic [31:0] exp_r15;
    } vec_t;

    localparam int NV = 14;
    // Sequence starts from the reset word 0C000003 (supervisor, masks set).
    localparam vec_t VECS [NV] = '{
        '{4'd3,  1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b1,1'b1, 32'h1234_5678, 1'b1, 32'h0C00_0003}, // R3
        '{4'd5,  1'b1,1'b0,1'b0, 1'b1,1'b0,1'b0,1'b0,1'b1, 32'h8000_0000, 1'b1, 32'hAC00_0003}, // R4
        '{4'd5,  1'b1,1'b0,1'b1, 1'b0,1'b1,1'b1,1'b1,1'b0, 32'h0000_0000, 1'b1, 32'h7C00_0003}, // R5
        '{4'd2,  1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_0001, 1'b1, 32'h1C00_0003}, // R4 V kept
        '{4'd0,  1'b0,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1,1'b1, 32'hDEAD_BEEF, 1'b0, 32'h1C00_0003}, // R6
        '{4'd0,  1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b1, 32'hFFFF_FFF0, 1'b0, 32'h8C00_0003}, // R6 R5
        '{4'd15, 1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'hFFFF_FFFF, 1'b0, 32'h8FFF_FFFF}, // R7
        '{4'd15, 1'b0,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h0000_0000, 1'b0, 32'h8FFF_FFFF}, // R10
        '{4'd15, 1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h4800_1002, 1'b0, 32'h4800_1002}, // R8
        '{4'd15, 1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h3000_0001, 1'b0, 32'h3000_1001}, // R10
        '{4'd15, 1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h9000_0000, 1'b0, 32'h9000_0000}, // R8 to user
        '{4'd15, 1'b1,1'b0,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'h6C00_00FF, 1'b0, 32'h6000_00FC}, // R9
        '{4'd15, 1'b1,1'b1,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0, 32'hFFFF_FFFF, 1'b0, 32'hF000_00FC}, // R9 R10
        '{4'd7,  1'b0,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b1,1'b1, 32'hCAFE_0001, 1'b1, 32'hF000_00FC}  // R3
    };

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    // Drive one commit, check the write port before the edge and state after.
    task automatic apply(input vec_t v, input string req);
        @(negedge clk);
        commit_valid = 1'b1;
        dest = v.dest; set_flags = v.s; is_compare = v.cmp; arith_op = v.arith;
        alu_n = v.an; alu_z = v.az; alu_c = v.ac; alu_v = v.av; shift_c = v.sc;
        result = v.res;
        #1;
        check(rf_we == v.exp_we, req, 32'(rf_we), 32'(v.exp_we));
        if (v.exp_we) begin
            check(rf_waddr == v.dest && rf_wdata == v.res, req, rf_wdata, v.res);
        end
        @(posedge clk);
        #1;
        commit_valid = 1'b0;
        check(r15_q == v.exp_r15, req, r15_q, v.exp_r15);
    endtask

    initial begin : watchdog
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        check(r15_q == 32'h0C00_0003, "R1", r15_q, 32'h0C00_0003);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i], $sformatf("vector %0d (R3..R10)", i));
            if (i == 8) begin
                // R12 field views after the privileged load of 48001002
                check(flag_z && !flag_n && !flag_c && !flag_v, "R12 flags",
                      {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'h4);
                check(irq_mask && !fiq_mask, "R12 masks",
                      {30'd0, irq_mask, fiq_mask}, 32'h2);
                check(mode == 2'b10 && pc_q == 24'h000400, "R12 mode/pc",
                      {6'd0, pc_q, mode}, {6'd0, 24'h000400, 2'b10});
            end
            if (i == 10) begin
                check(mode == 2'b00, "R8 user entry", 32'(mode), 32'h0);
            end
        end

        // R2: inputs that would write everything, but no commit strobe
        @(negedge clk);
        commit_valid = 1'b0; dest = 4'd15; set_flags = 1'b1; is_compare = 1'b0;
        result = 32'h0000_0000; alu_n = 1'b1; alu_z = 1'b1;
        #1;
        check(rf_we == 1'b0, "R2 we", 32'(rf_we), 32'h0);
        @(posedge clk);
        #1;
        check(r15_q == 32'hF000_00FC, "R2 hold", r15_q, 32'hF000_00FC);
        dest = 4'd4;
        #1;
        check(rf_we == 1'b0, "R2 we dest4", 32'(rf_we), 32'h0);
        @(posedge clk);
        #1;
        check(r15_q == 32'hF000_00FC, "R2 hold dest4", r15_q, 32'hF000_00FC);

        // R1 mid-run reset restores supervisor state
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check(r15_q == 32'h0C00_0003, "R1 re-reset", r15_q, 32'h0C00_0003);
        @(negedge clk);
        rst_n = 1'b1;

        // R11: privileged flag-setting write to 15 still leaves the file alone
        apply('{4'd15, 1'b1,1'b0,1'b1, 1'b0,1'b0,1'b0,1'b0,1'b0,
                32'h0400_0013, 1'b0, 32'h0400_0013}, "R11");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule